// File: doc/BRIEF.md
# Toggle-Refreshed Serial Watchdog Supervisor

This block supervises a serial host by watching one bit carried in every accepted serial frame. The host keeps the system alive by flipping that bit from one frame to the next, and it must do so before a programmable number of timebase ticks have passed. If the ticks run out first, the supervisor falls into a fail state. It raises a fail flag and sends a one-cycle clear pulse to the configuration register bank.

The fail state ends only when a frame arrives with the watchdog bit at 1. A frame with the bit at 0 has no effect while the block is failed. From that point the supervisor treats 1 as the last seen bit value and starts a fresh timeout window. The block comes out of reset already in the fail state, so the host must open every session with a frame carrying the bit at 1.

The frame decoder sits upstream and presents one strobe per valid frame together with the decoded bit. A free-running prescaler supplies the tick.

Top module: `spi_toggle_watchdog`

## Requirements
- R1: While reset is asserted and after it is released, `failFlag` is 1 and `regClear` is 0.
- R2: In the fail state, a valid frame whose watchdog bit is 0 leaves `failFlag` at 1.
- R3: In the fail state, a valid frame whose watchdog bit is 1 drives `failFlag` to 0 on the next clock edge.
- R4: After recovery the stored previous bit is 1. A following frame with the bit at 1 does not restart the window, and a frame with the bit at 0 does restart it.
- R5: In normal operation, the `TIMEOUT_TICKS`-th tick after the window was last restarted, with no toggle in the same cycle, sets `failFlag` on the next clock edge.
- R6: A valid frame whose watchdog bit differs from the stored previous value restarts the tick count from zero.
- R7: A valid frame whose watchdog bit equals the stored previous value does not restart the tick count.
- R8: `regClear` is high for exactly one cycle, namely the first cycle in which `failFlag` is high after a timeout. Recovery never raises it, and neither does reset.
- R9: `failFlag` stays high for the whole fail state. Ticks during that state cause no further `regClear` pulses.
- R10: When a toggle frame and the expiring tick arrive in the same cycle, the toggle wins and no fail occurs.
- R11: The watchdog bit is ignored in any cycle where `frameValid` is 0.
- R12: Under arbitrary mixes of frames, bit values and ticks, both outputs follow R2 to R11 cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | One-cycle strobe marking a complete valid frame |
| frameWdBit | input | 1 | Watchdog bit of that frame |
| tick | input | 1 | Timebase tick strobe |
| failFlag | output | 1 | High for the whole fail state |
| regClear | output | 1 | One-cycle clear pulse to the register bank on fail entry |

## Verification
Several properties are checked on every cycle. The clear pulse must last one cycle and must coincide exactly with the rising edge of the fail flag. A frame with the bit at 1 must always end the fail state. Without such a frame the fail state must hold. The block must never fail in a cycle without a tick.

Other behaviours depend on the hidden previous bit and the tick count, and only the bench scenarios can show them. These are: the exact tick on which the timeout fires, the restart on a toggle, the absence of a restart for a repeated bit, the stored value of 1 after recovery, and the toggle winning over an expiring tick.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;
  typedef enum logic {
    ST_FAIL = 1'b0,
    ST_RUN  = 1'b1
  } wdState_t;

  typedef struct packed {
    logic clrCount;
    logic countEn;
    logic loadPrev;
    logic prevVal;
  } wdStrobes_t;
endpackage

// File: rtl/wdsup_datapath.sv
module wdsup_datapath
  import wdsup_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frameValid,
  input  logic       frameWdBit,
  input  logic       tick,
  input  wdStrobes_t strb,
  output logic       toggleSeen,
  output logic       expireNow
);
  localparam int CNT_W = (TIMEOUT_TICKS < 2) ? 1 : $clog2(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] tickCount;
  logic             prevBit;

  assign toggleSeen = frameValid && (frameWdBit != prevBit);
  assign expireNow  = tick && (tickCount == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCount <= '0;
    end else if (strb.clrCount) begin
      tickCount <= '0;
    end else if (strb.countEn) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevBit <= 1'b0;
    end else if (strb.loadPrev) begin
      prevBit <= strb.prevVal;
    end
  end
endmodule

// File: rtl/wdsup_control.sv
module wdsup_control
  import wdsup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frameValid,
  input  logic       frameWdBit,
  input  logic       tick,
  input  logic       toggleSeen,
  input  logic       expireNow,
  output wdStrobes_t strb,
  output logic       failFlag,
  output logic       regClear
);
  wdState_t state, stateNext;
  logic     clearNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    clearNext = 1'b0;
    unique case (state)
      ST_FAIL: begin
        strb.clrCount = 1'b1;
        if (frameValid && frameWdBit) begin
          strb.loadPrev = 1'b1;
          strb.prevVal  = 1'b1;
          stateNext     = ST_RUN;
        end
      end
      ST_RUN: begin
        if (toggleSeen) begin
          strb.loadPrev = 1'b1;
          strb.prevVal  = frameWdBit;
          strb.clrCount = 1'b1;
        end else if (expireNow) begin
          strb.clrCount = 1'b1;
          stateNext     = ST_FAIL;
          clearNext     = 1'b1;
        end else if (tick) begin
          strb.countEn = 1'b1;
        end
      end
      default: stateNext = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FAIL;
      regClear <= 1'b0;
    end else begin
      state    <= stateNext;
      regClear <= clearNext;
    end
  end

  assign failFlag = (state == ST_FAIL);
endmodule

// File: rtl/spi_toggle_watchdog.sv
module spi_toggle_watchdog
  import wdsup_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frameValid,
  input  logic frameWdBit,
  input  logic tick,
  output logic failFlag,
  output logic regClear
);
  wdStrobes_t strb;
  logic       toggleSeen;
  logic       expireNow;

  wdsup_datapath #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_datapath (
    .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .frameWdBit(frameWdBit),
    .tick(tick), .strb(strb), .toggleSeen(toggleSeen), .expireNow(expireNow)
  );

  wdsup_control u_control (
    .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .frameWdBit(frameWdBit),
    .tick(tick), .toggleSeen(toggleSeen), .expireNow(expireNow), .strb(strb),
    .failFlag(failFlag), .regClear(regClear)
  );
endmodule

// File: rtl/wdsup_checker.sv
module wdsup_checker (
  input logic clk,
  input logic rst_n,
  input logic frameValid,
  input logic frameWdBit,
  input logic tick,
  input logic failFlag,
  input logic regClear
);
  // R8: clear lasts a single cycle
  a_r8_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
    regClear |=> !regClear);
  // R8: clear appears exactly when the fail flag rises
  a_r8_clear_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failFlag) |-> regClear);
  a_r8_rise_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    regClear |-> $rose(failFlag));
  // R3: a bit-1 frame ends the fail state
  a_r3_exit_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    (failFlag && frameValid && frameWdBit) |=> !failFlag);
  // R2: without a bit-1 frame the fail state holds
  a_r2_hold_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (failFlag && !(frameValid && frameWdBit)) |=> failFlag);
  // R5: fail entry needs a tick
  a_r5_fail_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!failFlag && !tick) |=> !failFlag);
  // R1: no clear pulse while the reset is held
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!regClear && failFlag);
  end
endmodule

bind spi_toggle_watchdog wdsup_checker u_wdsup_checker (
  .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .frameWdBit(frameWdBit),
  .tick(tick), .failFlag(failFlag), .regClear(regClear)
);

// File: tb/spi_toggle_watchdog_bench.sv
module spi_toggle_watchdog_bench;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frameValid = 1'b0;
  logic frameWdBit = 1'b0;
  logic tick = 1'b0;
  logic failFlag, regClear;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit mFail = 1'b1;
  bit mPrev = 1'b0;
  bit mClr  = 1'b0;
  int mCnt  = 0;

  always #4 clk = ~clk;

  spi_toggle_watchdog #(.TIMEOUT_TICKS(N)) u_spi_toggle_watchdog (
    .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .frameWdBit(frameWdBit),
    .tick(tick), .failFlag(failFlag), .regClear(regClear)
  );

  function automatic void modelStep(input bit fv, input bit b, input bit tk);
    mClr = 1'b0;
    if (mFail) begin
      if (fv && b) begin
        mFail = 1'b0; mPrev = 1'b1; mCnt = 0;
      end
    end else if (fv && (b != mPrev)) begin
      mPrev = b; mCnt = 0;
    end else if (tk) begin
      if (mCnt == N - 1) begin
        mFail = 1'b1; mClr = 1'b1; mCnt = 0;
      end else begin
        mCnt++;
      end
    end
  endfunction

  task automatic check(input string tag);
    checks++;
    if (failFlag !== mFail) begin
      errors++;
      $display("FAIL %s failFlag actual=%b expected=%b at cycle %0d", tag, failFlag, mFail, cycles);
    end
    checks++;
    if (regClear !== mClr) begin
      errors++;
      $display("FAIL %s regClear actual=%b expected=%b at cycle %0d", tag, regClear, mClr, cycles);
    end
  endtask

  task automatic step(input bit fv, input bit b, input bit tk, input string tag);
    @(negedge clk);
    frameValid = fv; frameWdBit = b; tick = tk;
    @(posedge clk);
    modelStep(fv, b, tk);
    #1;
    check(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, "R1");
    // fail state ignores bit 0
    step(1, 0, 1, "R2");
    step(1, 0, 1, "R9");
    // bit 1 without valid strobe is ignored
    step(0, 1, 0, "R11");
    step(1, 1, 0, "R3");
    // same bit 1 after recovery: no restart, tick counts
    step(1, 1, 1, "R4");
    for (int i = 0; i < N - 2; i++) step(0, 1, 1, "R7");
    step(0, 0, 1, "R5");
    step(0, 0, 0, "R8");
    step(0, 0, 1, "R9");
    // recover then toggle to 0
    step(1, 1, 0, "R3");
    step(1, 0, 1, "R4");
    for (int i = 0; i < N - 1; i++) step(0, 0, 1, "R6");
    step(1, 0, 0, "R7");
    step(1, 1, 1, "R10");
    for (int i = 0; i < N - 1; i++) step(0, 0, 1, "R6");
    step(0, 1, 1, "R11");
    step(0, 0, 0, "R8");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit fv, b, tk;
      fv = ($urandom_range(0, 99) < 20);
      b  = $urandom_range(0, 1);
      tk = ($urandom_range(0, 99) < 45);
      step(fv, b, tk, "R12");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule